// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single-cycle write requests from synchronous logic into a correctly ordered pin sequence for an external asynchronous static RAM. The memory has 17 address bits and 8 data bits by default. The block drives two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. The data bus is driven through a pad-style pair: a data value and a drive enable, which the pad turns into a tri-state driver. Every timing interval is a whole number of clock cycles, set by a parameter. The intervals are: address setup, minimum window width, data setup, data hold, write recovery, minimum cycle time, and the memory's output turn-off time.

The block offers two write styles. In strobe-bounded mode the chip selects go active at acceptance, and the write strobe opens and closes the window. In select-bounded mode the write strobe goes low at acceptance, and the chip selects open and close the window. Because the selects activate after the strobe is already low, the memory never turns its outputs on in this mode.

A parameter states whether the output enable is held active during writes. When it is held active in strobe-bounded mode, the window is stretched and the data drive is delayed by the turn-off count, so that the memory has released the bus before the sequencer drives it. Address and data are captured at acceptance. `busy` stays high until the whole cycle, including recovery, has elapsed.

Top module: `sram_write_seq`

## Requirements
- R1: Out of reset, and whenever `busy` is low, the pins are idle: `mem_sel_n`=1, `mem_sel`=0, `mem_wstb_n`=1, `mem_dq_oe`=0, and `busy`=0.
- R2: `mem_addr` never changes while the write window is open. The window is open when `mem_sel_n`=0, `mem_sel`=1 and `mem_wstb_n`=0 all at once.
- R3: In strobe-bounded mode (`ENABLE_BOUNDED`=0), both selects are already active in the cycle before the strobe falls. The strobe stays low for exactly max(T_WP, T_DW + Z) cycles, where Z = T_WHZ if `OE_LOW_DURING_WRITE`=1 and Z = 0 otherwise.
- R4: In select-bounded mode (`ENABLE_BOUNDED`=1), the strobe is already low in the cycle before the selects activate. The selects stay active for exactly max(T_WP, T_DW) cycles.
- R5: The address is stable for exactly T_AS cycles before the window opens.
- R6: `mem_dq_oe` rises Z cycles after the window opens, and the data stays stable while driven. It is therefore driven for max(T_WP, T_DW + Z) − Z cycles before the window closes, and never while the memory can still be driving.
- R7: `mem_dq_oe` stays high for exactly T_DH cycles after the window closes, then drops.
- R8: `busy` lasts max(T_WC, T_AS + window + T_DH + T_WR) cycles per write. The address is held for at least T_WR cycles after the window closes. A request is accepted only while `busy` is low.
- R9: The byte on the bus at the closing edge, and the address written, equal the `wdata` and `addr` sampled in the acceptance cycle. Later changes to these inputs are ignored.
- R10: `mem_oen` is constantly 0 when `OE_LOW_DURING_WRITE`=1 and constantly 1 otherwise.
- R11: A `req` raised while `busy` is high starts no write and changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Write request, sampled while busy is low |
| addr | input | ADDR_W | Write address, captured at acceptance |
| wdata | input | DATA_W | Write byte, captured at acceptance |
| busy | output | 1 | High from acceptance to end of recovery |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_wstb_n | output | 1 | Active-low write strobe |
| mem_oen | output | 1 | Active-low output enable, fixed by parameter |
| mem_dq_o | output | DATA_W | Data value for the bus pad |
| mem_dq_oe | output | 1 | Bus pad drive enable (0 = high impedance) |

## Verification
A wrong state or a wrong counter value shows at the pins within the same write. A state held too long or cut short changes the measured window width, the data setup or hold count, or the recovery count by at least one cycle. A mis-decoded mode shows as the wrong select and strobe order on the cycle the window opens. If data is driven too early, it overlaps the model memory's turn-off period and is counted as contention. If capture happens at the wrong time, a wrong byte is stored, which readback after each write reveals. A broken acceptance guard shows as an extra write count or a stray byte.

// File: rtl/sram_seq_pkg.sv
// Shared types and elaboration-time timing arithmetic for the SRAM write
// sequencer. All results are cycle counts; callers guarantee inputs >= 1.
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_WINDOW,
        ST_HOLD,
        ST_RECOVER
    } seq_state_e;

    // Larger of two counts
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Cycles at the start of the window during which the memory may still drive
    function automatic int turnoff_wait(input int t_whz, input bit oe_low,
                                        input bit sel_bounded);
        return (oe_low && !sel_bounded) ? t_whz : 0;
    endfunction

    // Window length: minimum width, stretched to fit turn-off plus data setup
    function automatic int window_len(input int t_wp, input int t_dw,
                                      input int twz);
        return max2(t_wp, twz + t_dw);
    endfunction

    // Recovery length: write recovery, stretched to meet the minimum cycle
    function automatic int recover_len(input int t_as, input int win,
                                       input int t_dh, input int t_wr,
                                       input int t_wc);
        int body;
        body = t_as + win + t_dh;
        return max2(t_wr, t_wc - body);
    endfunction

    // Counter width able to hold a count of value maxv
    function automatic int count_width(input int maxv);
        return max2(1, $clog2(maxv + 1));
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Phase down-counter. A load sets the phase length L; the count then steps
// L, L-1, ... 1 and flags expiry on 1, so a phase lasts exactly L cycles.
// Assumes every loaded length is at least 1. Exposes the next count so the
// pin stage can register decodes aligned with the state register.
module sram_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt_d,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    // Next count: reload, or step down and stop at zero
    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CW'(1));

endmodule

// File: rtl/sram_seq_ctrl.sv
// Sequencer state machine: idle, address setup, open window, data hold,
// recovery. Accepts a request only in idle. Each phase length is a
// parameter of at least one cycle, timed by the phase counter.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int T_AS = 1,
    parameter int WIN  = 3,
    parameter int T_DH = 1,
    parameter int REC  = 1,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          expire,
    output seq_state_e    state_q,
    output seq_state_e    state_d,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept
);
    // Next state and phase length on each transition
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    state_d  = ST_ADDR_SETUP;
                    load     = 1'b1;
                    load_val = CW'(T_AS);
                end
            end
            ST_ADDR_SETUP: begin
                if (expire) begin
                    state_d  = ST_WINDOW;
                    load     = 1'b1;
                    load_val = CW'(WIN);
                end
            end
            ST_WINDOW: begin
                if (expire) begin
                    state_d  = ST_HOLD;
                    load     = 1'b1;
                    load_val = CW'(T_DH);
                end
            end
            ST_HOLD: begin
                if (expire) begin
                    state_d  = ST_RECOVER;
                    load     = 1'b1;
                    load_val = CW'(REC);
                end
            end
            ST_RECOVER: begin
                if (expire)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/sram_seq_pins.sv
// Pin stage: captures address and data at acceptance and registers every
// memory control pin from the next state, so pins are glitch-free flops
// aligned with the state register. The mode parameter picks which control
// bounds the window; the other one spans the whole request.
module sram_seq_pins
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W         = 17,
    parameter int DATA_W         = 8,
    parameter int WIN            = 3,
    parameter int TWZ            = 0,
    parameter int CW             = 4,
    parameter bit ENABLE_BOUNDED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  seq_state_e        state_d,
    input  logic [CW-1:0]     cnt_d,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wstb_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);
    // Window counts down WIN..1; drive once TWZ cycles have passed
    localparam logic [CW-1:0] DRIVE_AT = CW'(WIN - TWZ);

    logic active_d, win_d, drive_d;
    logic sel_n_d, sel_d, wstb_n_d;

    assign active_d = (state_d != ST_IDLE);
    assign win_d    = (state_d == ST_WINDOW);
    assign drive_d  = (win_d && (cnt_d <= DRIVE_AT)) || (state_d == ST_HOLD);

    generate
        if (ENABLE_BOUNDED) begin : g_sel_bound
            assign wstb_n_d = !active_d;
            assign sel_n_d  = !win_d;
            assign sel_d    = win_d;
        end else begin : g_stb_bound
            assign wstb_n_d = !win_d;
            assign sel_n_d  = !active_d;
            assign sel_d    = active_d;
        end
    endgenerate

    // Address and data capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= addr_in;
            mem_dq_o <= wdata_in;
        end
    end

    // Registered control pins and bus drive enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n  <= 1'b1;
            mem_sel    <= 1'b0;
            mem_wstb_n <= 1'b1;
            mem_dq_oe  <= 1'b0;
        end else begin
            mem_sel_n  <= sel_n_d;
            mem_sel    <= sel_d;
            mem_wstb_n <= wstb_n_d;
            mem_dq_oe  <= drive_d;
        end
    end

endmodule

// File: rtl/sram_write_seq.sv
// Top of the asynchronous SRAM write sequencer. Derives phase lengths from
// the timing parameters (all in clock cycles, each at least 1 except T_WHZ)
// and wires the state machine, phase counter and pin stage together.
module sram_write_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W              = 17,
    parameter int DATA_W              = 8,
    parameter int T_AS                = 1,
    parameter int T_WP                = 3,
    parameter int T_DW                = 2,
    parameter int T_DH                = 1,
    parameter int T_WR                = 1,
    parameter int T_WC                = 8,
    parameter int T_WHZ               = 2,
    parameter bit OE_LOW_DURING_WRITE = 1'b1,
    parameter bit ENABLE_BOUNDED      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wstb_n,
    output logic              mem_oen,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);
    localparam int TWZ  = turnoff_wait(T_WHZ, OE_LOW_DURING_WRITE, ENABLE_BOUNDED);
    localparam int WIN  = window_len(T_WP, T_DW, TWZ);
    localparam int REC  = recover_len(T_AS, WIN, T_DH, T_WR, T_WC);
    localparam int MAXL = max2(max2(T_AS, WIN), max2(T_DH, REC));
    localparam int CW   = count_width(MAXL);

    seq_state_e    state_q, state_d;
    logic          load, expire, accept;
    logic [CW-1:0] load_val, cnt_d;

    sram_seq_ctrl #(
        .T_AS (T_AS),
        .WIN  (WIN),
        .T_DH (T_DH),
        .REC  (REC),
        .CW   (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .expire   (expire),
        .state_q  (state_q),
        .state_d  (state_d),
        .load     (load),
        .load_val (load_val),
        .accept   (accept)
    );

    sram_seq_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .cnt_d    (cnt_d),
        .expire   (expire)
    );

    sram_seq_pins #(
        .ADDR_W         (ADDR_W),
        .DATA_W         (DATA_W),
        .WIN            (WIN),
        .TWZ            (TWZ),
        .CW             (CW),
        .ENABLE_BOUNDED (ENABLE_BOUNDED)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .addr_in    (addr),
        .wdata_in   (wdata),
        .state_d    (state_d),
        .cnt_d      (cnt_d),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_wstb_n (mem_wstb_n),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe)
    );

    assign busy    = (state_q != ST_IDLE);
    assign mem_oen = !OE_LOW_DURING_WRITE;

endmodule

// File: rtl/sram_write_seq_chk.sv
// Protocol checker for the SRAM write sequencer, attached by bind. Watches
// only the top-level ports; assumes the synchronous active-low reset.
module sram_write_seq_chk #(
    parameter int ADDR_W         = 17,
    parameter int DATA_W         = 8,
    parameter bit ENABLE_BOUNDED = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wstb_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    logic win;
    assign win = !mem_sel_n && mem_sel && !mem_wstb_n;

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_sel_n && !mem_sel && mem_wstb_n && !mem_dq_oe));

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win && $past(win)) |-> $stable(mem_addr));

    // R6
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

    // R7
    hold_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && $past(win)) |-> mem_dq_oe);

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req) && !$past(busy)) |-> busy);

    generate
        if (ENABLE_BOUNDED) begin : g_sel_order
            // R4
            sel_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (win && !$past(win)) |-> $past(!mem_wstb_n));
        end else begin : g_stb_order
            // R3
            stb_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (win && !$past(win)) |-> $past(!mem_sel_n && mem_sel));
        end
    endgenerate

endmodule

bind sram_write_seq sram_write_seq_chk #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .ENABLE_BOUNDED (ENABLE_BOUNDED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .busy       (busy),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_wstb_n (mem_wstb_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_write_seq.sv
`timescale 1ns/1ps

// Pin-level memory model: samples pins between edges, stores the byte seen
// at each window close, measures interval lengths in cycles, and counts
// address changes in an open window and bus contention with its own outputs.
module sram_pin_model #(
    parameter int AW  = 17,
    parameter int DW  = 8,
    parameter int WHZ = 2
) (
    input logic          clk,
    input logic [AW-1:0] addr,
    input logic          sel_n,
    input logic          sel,
    input logic          wstb_n,
    input logic          oen,
    input logic [DW-1:0] dq_o,
    input logic          dq_oe
);
    logic [DW-1:0] mem [int];
    int last_win, last_as, last_dsu, last_dh, last_rec, last_pre_sel, last_pre_stb;
    int writes, addr_viol, contention, bad_data;
    int win_cnt, addr_age, drv_cnt, hcnt, post, whz_cnt;
    bit win_p, oe_p, wstb_p, selon_p, in_hold, active;
    logic [AW-1:0] addr_p;
    logic [DW-1:0] dq_p;

    initial begin
        win_p = 0; oe_p = 0; wstb_p = 1; selon_p = 0; in_hold = 0; active = 0;
        addr_p = '0; dq_p = '0;
    end

    function automatic int read(input int a);
        if (mem.exists(a)) return int'(mem[a]);
        return -1;
    endfunction

    always @(negedge clk) begin : sample
        bit win, selon;
        selon = !sel_n && sel;
        win = selon && !wstb_n;
        if (addr !== addr_p) begin
            if (win || win_p) addr_viol++;
            if (!win) last_rec = post;
            addr_age = 0;
        end else addr_age++;
        if (win && !win_p) begin
            last_as = addr_age; win_cnt = 0;
            last_pre_sel = int'(selon_p); last_pre_stb = int'(!wstb_p);
        end
        if (win) win_cnt++;
        if (!win && win_p) begin
            last_win = win_cnt; last_dsu = drv_cnt; writes++;
            if (oe_p) mem[int'(addr_p)] = dq_p; else bad_data++;
            in_hold = 1; hcnt = 0; post = 0;
        end
        if (!win) post++;
        if (in_hold) begin
            if (dq_oe) hcnt++;
            else begin last_dh = hcnt; in_hold = 0; end
        end
        if (dq_oe) drv_cnt = (oe_p && dq_o == dq_p) ? drv_cnt + 1 : 1;
        else drv_cnt = 0;
        if (!selon || oen) begin
            active = 0; whz_cnt = 0;
        end else if (!wstb_n) begin
            if (active && dq_oe) contention++;
            whz_cnt++;
            if (whz_cnt >= WHZ) active = 0;
        end else begin
            whz_cnt = 0;
            if (wstb_p) active = 1;
            if (active && dq_oe) contention++;
        end
        win_p = win; oe_p = dq_oe; wstb_p = wstb_n; selon_p = selon;
        addr_p = addr; dq_p = dq_o;
    end
endmodule

module test_sram_write_seq;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req = 0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    int n_chk = 0, n_err = 0;
    int blen_a = 0, blen_b = 0, blen_c = 0;

    always #2 clk = ~clk;

    // A: strobe-bounded, OE low, short T_WC; B: strobe-bounded, OE high;
    // C: select-bounded, OE low.
    logic        busy_a, sel_n_a, sel_a, wstb_n_a, oen_a, dq_oe_a;
    logic        busy_b, sel_n_b, sel_b, wstb_n_b, oen_b, dq_oe_b;
    logic        busy_c, sel_n_c, sel_c, wstb_n_c, oen_c, dq_oe_c;
    logic [16:0] maddr_a, maddr_b, maddr_c;
    logic [7:0]  dq_a, dq_b, dq_c;

    sram_write_seq #(.T_WC(6), .OE_LOW_DURING_WRITE(1'b1), .ENABLE_BOUNDED(1'b0)) i_sram_write_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata), .busy(busy_a),
        .mem_addr(maddr_a), .mem_sel_n(sel_n_a), .mem_sel(sel_a), .mem_wstb_n(wstb_n_a),
        .mem_oen(oen_a), .mem_dq_o(dq_a), .mem_dq_oe(dq_oe_a));
    sram_write_seq #(.T_WC(8), .OE_LOW_DURING_WRITE(1'b0), .ENABLE_BOUNDED(1'b0)) i_sram_write_seq_b (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata), .busy(busy_b),
        .mem_addr(maddr_b), .mem_sel_n(sel_n_b), .mem_sel(sel_b), .mem_wstb_n(wstb_n_b),
        .mem_oen(oen_b), .mem_dq_o(dq_b), .mem_dq_oe(dq_oe_b));
    sram_write_seq #(.T_WC(8), .OE_LOW_DURING_WRITE(1'b1), .ENABLE_BOUNDED(1'b1)) i_sram_write_seq_c (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata), .busy(busy_c),
        .mem_addr(maddr_c), .mem_sel_n(sel_n_c), .mem_sel(sel_c), .mem_wstb_n(wstb_n_c),
        .mem_oen(oen_c), .mem_dq_o(dq_c), .mem_dq_oe(dq_oe_c));

    sram_pin_model m_a (.clk(clk), .addr(maddr_a), .sel_n(sel_n_a), .sel(sel_a),
        .wstb_n(wstb_n_a), .oen(oen_a), .dq_o(dq_a), .dq_oe(dq_oe_a));
    sram_pin_model m_b (.clk(clk), .addr(maddr_b), .sel_n(sel_n_b), .sel(sel_b),
        .wstb_n(wstb_n_b), .oen(oen_b), .dq_o(dq_b), .dq_oe(dq_oe_b));
    sram_pin_model m_c (.clk(clk), .addr(maddr_c), .sel_n(sel_n_c), .sel(sel_c),
        .wstb_n(wstb_n_c), .oen(oen_c), .dq_o(dq_c), .dq_oe(dq_oe_c));

    // Free-running busy-cycle counters
    always @(negedge clk) begin
        if (busy_a) blen_a++;
        if (busy_b) blen_b++;
        if (busy_c) blen_c++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy_a || busy_b || busy_c);
        @(negedge clk);
    endtask

    task automatic issue(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1; addr = a; wdata = d;
        @(negedge clk);
        req = 0;
    endtask

    // Reset state and fixed output enable
    task automatic t_reset();
        rst_n = 0; req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy A", int'(busy_a), 0);
        chk("R1 busy C", int'(busy_c), 0);
        chk("R1 sel_n A", int'(sel_n_a), 1);
        chk("R1 sel A", int'(sel_a), 0);
        chk("R1 wstb_n C", int'(wstb_n_c), 1);
        chk("R1 sel_n C", int'(sel_n_c), 1);
        chk("R1 dq_oe B", int'(dq_oe_b), 0);
        chk("R10 oen A", int'(oen_a), 0);
        chk("R10 oen B", int'(oen_b), 1);
        chk("R10 oen C", int'(oen_c), 0);
    endtask

    // One write, all timing intervals and stored byte
    task automatic t_write(input logic [16:0] a, input logic [7:0] d);
        int sa, sb, sc;
        sa = blen_a; sb = blen_b; sc = blen_c;
        issue(a, d);
        wait_idle();
        chk("R3 strobe width OE low", m_a.last_win, 4);
        chk("R3 strobe width OE high", m_b.last_win, 3);
        chk("R3 selects before strobe", m_a.last_pre_sel, 1);
        chk("R4 select width", m_c.last_win, 3);
        chk("R4 strobe before selects", m_c.last_pre_stb, 1);
        chk("R5 addr setup A", m_a.last_as, 1);
        chk("R5 addr setup C", m_c.last_as, 1);
        chk("R6 data setup A", m_a.last_dsu, 2);
        chk("R6 data setup B", m_b.last_dsu, 3);
        chk("R6 data setup C", m_c.last_dsu, 3);
        chk("R7 data hold A", m_a.last_dh, 1);
        chk("R7 data hold C", m_c.last_dh, 1);
        chk("R8 busy length A", blen_a - sa, 7);
        chk("R8 busy length B", blen_b - sb, 8);
        chk("R8 busy length C", blen_c - sc, 8);
        chk("R9 stored A", m_a.read(int'(a)), int'(d));
        chk("R9 stored B", m_b.read(int'(a)), int'(d));
        chk("R9 stored C", m_c.read(int'(a)), int'(d));
    endtask

    // Request and input changes while busy
    task automatic t_ignore_busy();
        int wa, wc;
        wa = m_a.writes; wc = m_c.writes;
        issue(17'h01111, 8'h11);
        req = 1; addr = 17'h02222; wdata = 8'h22;
        @(negedge clk);
        req = 0;
        wait_idle();
        chk("R11 one write A", m_a.writes - wa, 1);
        chk("R11 one write C", m_c.writes - wc, 1);
        chk("R11 no stray byte A", m_a.read(32'h2222), -1);
        chk("R11 no stray byte B", m_b.read(32'h2222), -1);
        chk("R9 captured byte A", m_a.read(32'h1111), 8'h11);
        chk("R9 captured byte C", m_c.read(32'h1111), 8'h11);
    endtask

    // Request held high across two writes: recovery and spacing
    task automatic t_back_to_back();
        bit sa, sb, sc;
        sa = 0; sb = 0; sc = 0;
        @(negedge clk);
        req = 1; addr = 17'h03333; wdata = 8'h33;
        @(negedge clk);
        addr = 17'h04444; wdata = 8'h44;
        forever begin
            @(negedge clk);
            if (!busy_a) sa = 1;
            if (!busy_b) sb = 1;
            if (!busy_c) sc = 1;
            if (sa && sb && sc && busy_a && busy_b && busy_c) break;
        end
        req = 0;
        wait_idle();
        chk("R8 recovery A", m_a.last_rec, 3);
        chk("R8 recovery B", m_b.last_rec, 5);
        chk("R8 recovery C", m_c.last_rec, 5);
        chk("R9 first byte A", m_a.read(32'h3333), 8'h33);
        chk("R9 second byte A", m_a.read(32'h4444), 8'h44);
        chk("R9 second byte C", m_c.read(32'h4444), 8'h44);
    endtask

    task automatic t_final();
        chk("R2 addr change in window A", m_a.addr_viol, 0);
        chk("R2 addr change in window C", m_c.addr_viol, 0);
        chk("R6 contention A", m_a.contention, 0);
        chk("R6 contention C", m_c.contention, 0);
        chk("R9 undriven close B", m_b.bad_data, 0);
    endtask

    initial begin
        t_reset();
        t_write(17'h12345, 8'hA5);
        t_write(17'h1FFFF, 8'hFF);
        t_write(17'h00000, 8'h00);
        t_write(17'h00F0F, 8'h5A);
        t_ignore_busy();
        t_back_to_back();
        t_final();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule